// File: doc/BRIEF.md
# Two-Lane Pixel Framer

The framer takes one pixel per pixel-clock period: 24 bits of colour (red, green and blue, eight bits each) together with horizontal sync, vertical sync and data enable. It turns every pixel into one fixed-length serial frame on each of two data lanes. Frames go out most significant bit first, one bit per cycle of a fast bit clock that runs at the frame length times the pixel rate. Each frame opens with a two-bit marker a receiver can lock onto again after a data or clock error, and it closes with an odd parity bit. The sync and enable bits are carried as they arrive; their polarity means nothing to the block.

The pixel clock is sampled in the bit-clock domain, and a rising edge starts a new frame. A second transport mode carries only six bits per colour: the two least significant bits of each colour are sent as zero and the frame length does not change. The block goes to sleep when the active-low power-down input is low, or when no pixel-clock edge has been seen for a set number of bit-clock cycles. While it sleeps both lanes hold zero. It wakes only on a pixel-clock edge, so framing always resumes at a pixel boundary. The clock lane is the bit clock gated off by the sleep indication.

Top module: `pixel_lane_framer`

## Requirements
- R1: A rising edge of `pix_clk` seen with `pd_n` high loads a new frame. The first frame bit appears on the lanes in the cycle after that edge is sampled, and `frame_start` is high for exactly that one cycle.
- R2: Each lane frame is 17 bits long and is sent most significant bit first, one bit per `clk` cycle. Bits 16:15 are the marker 1 then 0. After the last bit the lane shows 0 until the next frame.
- R3: Lane 0 frame layout: bits 14:7 = red[7:0], bits 6:3 = green[7:4], bit 2 = hsync, bit 1 = constant 0, bit 0 = parity.
- R4: Lane 1 frame layout: bits 14:11 = green[3:0], bits 10:3 = blue[7:0], bit 2 = vsync, bit 1 = data enable, bit 0 = parity.
- R5: Bit 0 of each frame makes the number of ones across all 17 bits odd.
- R6: With `mode24` low, bits 1:0 of red, green and blue are sent as 0. With `mode24` high, all colour bits are sent as they are.
- R7: Any combination of hsync, vsync and data enable, high or low, reaches its frame position unchanged.
- R8: While `pd_n` is low, `asleep` is high from the next cycle on, and pixel-clock edges start no frame.
- R9: After STOP_CYC+1 `clk` cycles with no pixel-clock rising edge, `asleep` goes high. Within that window it stays low.
- R10: Whenever `asleep` is high, both lanes output 0.
- R11: `asleep` falls only together with the start of a new frame: on the first pixel-clock edge seen with `pd_n` high. That frame is complete and correct.
- R12: After reset, `asleep` is high, both lanes are 0 and `frame_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, also used as the reference for the watchdog |
| rst | input | 1 | Synchronous active-high reset |
| pix_clk | input | 1 | Pixel clock, sampled in the `clk` domain |
| pd_n | input | 1 | Active-low power-down |
| mode24 | input | 1 | 1 = 24-bit colour transport, 0 = 18-bit |
| red | input | 8 | Red component |
| green | input | 8 | Green component |
| blue | input | 8 | Blue component |
| hsync | input | 1 | Horizontal sync, any polarity |
| vsync | input | 1 | Vertical sync, any polarity |
| den | input | 1 | Data enable, any polarity |
| lane0 | output | 1 | Serial data lane 0 |
| lane1 | output | 1 | Serial data lane 1 |
| frame_start | output | 1 | High while the first bit of a frame is on the lanes |
| asleep | output | 1 | Sleep state; the clock lane is gated off while high |

## Verification
The assertions take the pixel clock to be slow against the bit clock: its high and low phases each last at least one `clk` cycle, so two rising edges can never be sampled in adjacent cycles. Pixel data, mode and sync inputs must be stable around the sampled edge. The stimulus raises `pix_clk` for 8 cycles and lowers it for 9, and it changes every pixel input only in the same half cycle in which `pix_clk` rises. In a normal stream this gives exactly one edge per 17-bit frame. Stretches with the pixel clock stopped are made by holding `pix_clk` low.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
  localparam int COLOR_W = 8;
  localparam int HALF_W  = COLOR_W / 2;
  localparam int LANES   = 2;
  // marker(2) + 14 payload bits + parity(1)
  localparam int FRAME_W = 2 + COLOR_W + HALF_W + 2 + 1;
  localparam logic [1:0] MARKER = 2'b10;

  function automatic logic odd_fill(input logic [FRAME_W-2:0] body);
    return ~^body;
  endfunction
endpackage

// File: rtl/lfr_lane_packer.sv
module lfr_lane_packer
  import lfr_pkg::*;
#(
  parameter int DROP_W = 2
) (
  input  logic               mode24,
  input  logic [COLOR_W-1:0] red,
  input  logic [COLOR_W-1:0] green,
  input  logic [COLOR_W-1:0] blue,
  input  logic               hsync,
  input  logic               vsync,
  input  logic               den,
  output logic [FRAME_W-1:0] frame0,
  output logic [FRAME_W-1:0] frame1
);
  logic [COLOR_W-1:0] keep;
  logic [COLOR_W-1:0] rm, gm, bm;
  logic [FRAME_W-2:0] body0, body1;

  generate
    if (DROP_W > 0) begin : g_drop
      assign keep = mode24 ? {COLOR_W{1'b1}}
                           : {{(COLOR_W-DROP_W){1'b1}}, {DROP_W{1'b0}}};
    end else begin : g_keep
      assign keep = {COLOR_W{1'b1}};
    end
  endgenerate

  assign rm = red   & keep;
  assign gm = green & keep;
  assign bm = blue  & keep;

  assign body0  = {MARKER, rm, gm[COLOR_W-1:HALF_W], hsync, 1'b0};
  assign body1  = {MARKER, gm[HALF_W-1:0], bm, vsync, den};
  assign frame0 = {body0, odd_fill(body0)};
  assign frame1 = {body1, odd_fill(body1)};
endmodule

// File: rtl/lfr_lane_shift.sv
module lfr_lane_shift #(
  parameter int FW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          clear,
  input  logic [FW-1:0] frame,
  output logic          bit_o
);
  logic [FW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)        sh <= '0;
    else if (load)  sh <= frame;
    else if (clear) sh <= '0;
    else            sh <= {sh[FW-2:0], 1'b0};
  end

  assign bit_o = sh[FW-1];
endmodule

// File: rtl/lfr_clk_watch.sv
module lfr_clk_watch #(
  parameter int STOP_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic pd_n,
  output logic asleep
);
  localparam int CNT_W = $clog2(STOP_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STOP_CYC);

  logic [CNT_W-1:0] idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle   <= LIMIT;
      asleep <= 1'b1;
    end else begin
      if (rise)               idle <= '0;
      else if (idle != LIMIT) idle <= idle + 1'b1;

      if (!pd_n)              asleep <= 1'b1;
      else if (rise)          asleep <= 1'b0;
      else if (idle == LIMIT) asleep <= 1'b1;
    end
  end
endmodule

// File: rtl/pixel_lane_framer.sv
module pixel_lane_framer
  import lfr_pkg::*;
#(
  parameter int STOP_CYC = 64,
  parameter int DROP_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pix_clk,
  input  logic               pd_n,
  input  logic               mode24,
  input  logic [COLOR_W-1:0] red,
  input  logic [COLOR_W-1:0] green,
  input  logic [COLOR_W-1:0] blue,
  input  logic               hsync,
  input  logic               vsync,
  input  logic               den,
  output logic               lane0,
  output logic               lane1,
  output logic               frame_start,
  output logic               asleep
);
  logic pclk_d;
  logic pix_rise;
  logic load;
  logic clear;
  logic [LANES-1:0][FRAME_W-1:0] frames;
  logic [LANES-1:0]              lane_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      pclk_d      <= 1'b1;
      frame_start <= 1'b0;
    end else begin
      pclk_d      <= pix_clk;
      frame_start <= load;
    end
  end

  assign pix_rise = pix_clk & ~pclk_d;
  assign load     = pix_rise & pd_n;
  assign clear    = ~pd_n | asleep;

  lfr_lane_packer #(.DROP_W(DROP_W)) u_pack (
    .mode24 (mode24),
    .red    (red),
    .green  (green),
    .blue   (blue),
    .hsync  (hsync),
    .vsync  (vsync),
    .den    (den),
    .frame0 (frames[0]),
    .frame1 (frames[1])
  );

  lfr_clk_watch #(.STOP_CYC(STOP_CYC)) u_watch (
    .clk    (clk),
    .rst    (rst),
    .rise   (pix_rise),
    .pd_n   (pd_n),
    .asleep (asleep)
  );

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      lfr_lane_shift #(.FW(FRAME_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .clear (clear),
        .frame (frames[l]),
        .bit_o (lane_bits[l])
      );
    end
  endgenerate

  assign lane0 = lane_bits[0];
  assign lane1 = lane_bits[1];
endmodule

// File: rtl/pixel_lane_framer_checker.sv
module pixel_lane_framer_checker #(
  parameter int STOP_CYC = 64
) (
  input logic clk,
  input logic rst,
  input logic pd_n,
  input logic pix_rise,
  input logic lane0,
  input logic lane1,
  input logic frame_start,
  input logic asleep
);
  int unsigned idle_cnt;

  always_ff @(posedge clk) begin
    if (rst)                              idle_cnt <= STOP_CYC + 1;
    else if (pix_rise)                    idle_cnt <= 0;
    else if (idle_cnt < STOP_CYC + 1)     idle_cnt <= idle_cnt + 1;
  end

  a_r1_single_start: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  a_r2_marker_head: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (lane0 && lane1));

  a_r2_marker_second: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (!lane0 && !lane1));

  a_r8_pd_sleeps: assert property (@(posedge clk) disable iff (rst)
    !pd_n |=> asleep);

  a_r9_stop_sleeps: assert property (@(posedge clk) disable iff (rst)
    (idle_cnt > STOP_CYC) |-> asleep);

  a_r10_quiet_lanes: assert property (@(posedge clk) disable iff (rst)
    asleep |-> (!lane0 && !lane1));

  a_r11_wake_on_frame: assert property (@(posedge clk) disable iff (rst)
    $fell(asleep) |-> frame_start);
endmodule

bind pixel_lane_framer pixel_lane_framer_checker #(.STOP_CYC(STOP_CYC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pd_n        (pd_n),
  .pix_rise    (pix_rise),
  .lane0       (lane0),
  .lane1       (lane1),
  .frame_start (frame_start),
  .asleep      (asleep)
);

// File: tb/pixel_lane_framer_bench.sv
module pixel_lane_framer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FW         = 17;
  localparam int STOP_CYC   = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_clk = 1'b0;
  logic pd_n = 1'b1;
  logic mode24 = 1'b1;
  logic [7:0] red = '0, green = '0, blue = '0;
  logic hsync = 1'b0, vsync = 1'b0, den = 1'b0;
  logic lane0, lane1, frame_start, asleep;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_lane_framer #(.STOP_CYC(STOP_CYC)) u_pixel_lane_framer (
    .clk (clk), .rst (rst), .pix_clk (pix_clk), .pd_n (pd_n),
    .mode24 (mode24), .red (red), .green (green), .blue (blue),
    .hsync (hsync), .vsync (vsync), .den (den),
    .lane0 (lane0), .lane1 (lane1),
    .frame_start (frame_start), .asleep (asleep)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] model(input bit lane, input bit m24,
      input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
      input logic h, input logic v, input logic d);
    logic [7:0] msk;
    logic [FW-2:0] body;
    msk = m24 ? 8'hFF : 8'hFC;
    r = r & msk; g = g & msk; b = b & msk;
    if (!lane) body = {2'b10, r, g[7:4], h, 1'b0};
    else       body = {2'b10, g[3:0], b, v, d};
    return {body, ~^body};
  endfunction

  // One pixel period: 8 cycles high, 9 low. Captures both lane frames.
  task automatic send_pixel(input bit m24, input logic [7:0] r, input logic [7:0] g,
      input logic [7:0] b, input logic h, input logic v, input logic d,
      input bit expect_sleep, input string req);
    logic [FW-1:0] cap0, cap1, e0, e1;
    logic fs0;
    mode24 = m24; red = r; green = g; blue = b;
    hsync = h; vsync = v; den = d;
    pix_clk = 1'b1;
    fs0 = 1'b0;
    for (int i = 0; i < FW; i++) begin
      @(negedge clk);
      cap0[FW-1-i] = lane0;
      cap1[FW-1-i] = lane1;
      if (i == 0) fs0 = frame_start;
      if (i == 7) pix_clk = 1'b0;
    end
    e0 = expect_sleep ? '0 : model(1'b0, m24, r, g, b, h, v, d);
    e1 = expect_sleep ? '0 : model(1'b1, m24, r, g, b, h, v, d);
    check({req, " lane0"}, 32'(cap0), 32'(e0));
    check({req, " lane1"}, 32'(cap1), 32'(e1));
    check({req, " frame_start"}, 32'(fs0), 32'(!expect_sleep));
    check({req, " asleep"}, 32'(asleep), 32'(expect_sleep));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check("R12 asleep", 32'(asleep), 32'd1);
    check("R12 lanes", 32'({lane0, lane1}), 32'd0);
    check("R12 frame_start", 32'(frame_start), 32'd0);

    // R1 R2 R3 R4 R5 R7 R11: 24-bit sweep, first pixel is the wake-up
    for (int k = 0; k < 256; k++)
      send_pixel(1'b1, 8'(k), 8'((k*37 + 11) & 255), 8'(255 - k),
                 k[0], k[1], k[2], 1'b0, "R3_R4_R5_R7 sweep24");

    // R6: 18-bit transport
    for (int k = 0; k < 64; k++)
      send_pixel(1'b0, 8'(k*4 + 3), 8'((k*53 + 2) & 255), 8'((k*29 + 1) & 255),
                 k[2], k[0], k[1], 1'b0, "R6 sweep18");

    // R9: stopped pixel clock; stays awake inside the window
    repeat (30) @(negedge clk);
    check("R9 awake in window", 32'(asleep), 32'd0);
    repeat (40) @(negedge clk);
    check("R9 asleep after stop", 32'(asleep), 32'd1);
    check("R10 lanes quiet", 32'({lane0, lane1}), 32'd0);

    // R11: wake on first edge with a full frame
    send_pixel(1'b1, 8'hA5, 8'h3C, 8'h0F, 1'b1, 1'b0, 1'b1, 1'b0, "R11 wake");
    send_pixel(1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, "R5 all ones");
    send_pixel(1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R5 all zeros");

    // R8: power-down ignores pixel edges
    pd_n = 1'b0;
    @(negedge clk);
    check("R8 asleep", 32'(asleep), 32'd1);
    for (int k = 0; k < 3; k++)
      send_pixel(1'b1, 8'(k + 1), 8'h77, 8'h88, 1'b1, 1'b1, 1'b1, 1'b1, "R8_R10 pd");
    pd_n = 1'b1;
    send_pixel(1'b1, 8'h12, 8'h34, 8'h56, 1'b0, 1'b1, 1'b0, 1'b0, "R11 pd release");

    // R2: lane shows 0 after the last bit
    @(negedge clk);
    check("R2 tail zero", 32'({lane0, lane1}), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule